// File: doc/BRIEF.md
# Memory-Mapped Port Register Set with Macrocell Write Masking

This block gives a microcontroller register-level control of one 8-bit I/O port. The CPU reaches it through a small synchronous register bus that carries an address, write and read strobes, write data and registered read data. Behind that bus sit five things: a live view of the pin levels, an output data register, a direction register, a bank of output macrocell flip-flops, and a write-protect mask for that bank. Two read-only views are also on the bus. One shows the input macrocell latches and the other shows the per-pin driver enables.

The output macrocells can be loaded from either side. The CPU loads them through the bus, and only in the bit positions the mask leaves open. The programmable logic loads them through a next-state input with a load strobe. Each pin's driver enable is the OR of its direction bit and an enable term supplied by the logic. The input macrocells sample the pins while a latch-enable input is high and hold their value while it is low.

Top module: `ioport_regs`

## Requirements
- R1: A read of address 0 returns the pin levels present at the clock edge that samples the read strobe. No earlier latching applies to this path.
- R2: A write to address 1 stores the output data word. The word reads back at address 1 and appears on `pin_out` from the next cycle on.
- R3: `pin_oe` bit i is 1 when bit i of the direction register (address 2, read/write) is 1 or when `logic_oe` bit i is 1. Address 6 reads back this enable vector.
- R4: A CPU write to address 3 updates only the macrocell bits whose mask bit is 0. Bits whose mask bit is 1 keep their value unless a logic-side load is active in the same cycle.
- R5: The mask register at address 4 is read/write and resets to 0x00.
- R6: A read of address 3 returns the current macrocell flip-flops, and `mc_q` always shows them.
- R7: While `mc_load` is 1, a macrocell bit takes `mc_next`, except that an unmasked bit written by the CPU in the same cycle takes the CPU data.
- R8: On each rising clock edge with `imc_le` high, the input macrocells capture `pin_in`. While `imc_le` is low they hold. They read at address 5 and drive `imc_q`.
- R9: Writes to addresses 0, 5, 6 and 7 change no register.
- R10: Read data is registered. `bus_rdata` takes the selected value one cycle after `bus_rd` and holds it until the next read. Address 7 reads 0x00.
- R11: Reset clears the output data, direction, mask, both macrocell banks and the read data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Data driven toward the pads |
| pin_oe | output | 8 | Per-pin driver enable |
| logic_oe | input | 8 | Output-enable term from the logic array |
| mc_load | input | 1 | Logic-side macrocell load strobe |
| mc_next | input | 8 | Logic-side macrocell next state |
| mc_q | output | 8 | Output macrocell flip-flops |
| imc_le | input | 1 | Input macrocell latch enable |
| imc_q | output | 8 | Input macrocell outputs |

## Verification
The macrocell write is tried with three mask patterns: all bits blocked in the high nibble, no bits blocked, and a middle band blocked. These three separate correct per-bit masking from a mask that is ignored or inverted. A CPU write that coincides with a logic-side load, using different data on each side, shows which source wins in each bit class. The enable readback is tried with the direction register alone and with a disjoint logic term, which tells a true OR from either input alone. Writes to every read-only address are followed by reads of the registers they could disturb.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 3'd0,
        SEL_DOUT = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_OMC  = 3'd3,
        SEL_MASK = 3'd4,
        SEL_IMC  = 3'd5,
        SEL_OE   = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/ioport_ctrl.sv
module ioport_ctrl
    import ioport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      logic_oe,
    output logic [W-1:0]      dout_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      oe
);
    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] dir;
        logic [W-1:0] mask;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (reg_sel_e'(addr))
                SEL_DOUT: st_d.dout = wdata;
                SEL_DIR:  st_d.dir  = wdata;
                SEL_MASK: st_d.mask = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_q = st_q.dout;
    assign dir_q  = st_q.dir;
    assign mask_q = st_q.mask;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_oe
            assign oe[gi] = st_q.dir[gi] | logic_oe[gi];
        end
    endgenerate

    // R9: a write outside the writable locations leaves every control register unchanged
    p_ro_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != SEL_DOUT && addr != SEL_DIR && addr != SEL_MASK)
        |=> (dout_q == $past(dout_q) && dir_q == $past(dir_q) && mask_q == $past(mask_q)))
        else $error("p_ro_ignore_r9");

    // R5: the mask changes only through a write to its own address
    p_mask_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == SEL_MASK) |=> $stable(mask_q))
        else $error("p_mask_wr_r5");
endmodule

// File: rtl/ioport_macrocell.sv
module ioport_macrocell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mask,
    input  logic         mc_load,
    input  logic [W-1:0] mc_next,
    input  logic [W-1:0] pin_in,
    input  logic         imc_le,
    output logic [W-1:0] omc_q,
    output logic [W-1:0] imc_q
);
    typedef struct packed {
        logic [W-1:0] omc;
        logic [W-1:0] imc;
    } mc_t;

    mc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mc_load) st_d.omc = mc_next;
        if (cpu_wr)  st_d.omc = (wdata & ~mask) | (st_d.omc & mask);
        if (imc_le)  st_d.imc = pin_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign omc_q = st_q.omc;
    assign imc_q = st_q.imc;

    // R4: a CPU write alone never alters masked bits
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !mc_load) |=> ((omc_q & $past(mask)) == ($past(omc_q) & $past(mask))))
        else $error("p_mask_hold_r4");

    // R7: on unmasked bits the CPU data wins over a logic-side load
    p_cpu_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> ((omc_q & ~$past(mask)) == ($past(wdata) & ~$past(mask))))
        else $error("p_cpu_win_r7");

    // R8: input macrocells hold while the latch enable is low
    p_imc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !imc_le |=> $stable(imc_q))
        else $error("p_imc_hold_r8");
endmodule

// File: rtl/ioport_readmux.sv
module ioport_readmux
    import ioport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      pin_in,
    input  logic [W-1:0]      dout,
    input  logic [W-1:0]      dir,
    input  logic [W-1:0]      omc,
    input  logic [W-1:0]      mask,
    input  logic [W-1:0]      imc,
    input  logic [W-1:0]      oe,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            case (reg_sel_e'(addr))
                SEL_PIN:  rdata_d = pin_in;
                SEL_DOUT: rdata_d = dout;
                SEL_DIR:  rdata_d = dir;
                SEL_OMC:  rdata_d = omc;
                SEL_MASK: rdata_d = mask;
                SEL_IMC:  rdata_d = imc;
                SEL_OE:   rdata_d = oe;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R10: read data holds between read strobes
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata))
        else $error("p_rd_hold_r10");
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
    import ioport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    input  logic [W-1:0]      logic_oe,
    input  logic              mc_load,
    input  logic [W-1:0]      mc_next,
    output logic [W-1:0]      mc_q,
    input  logic              imc_le,
    output logic [W-1:0]      imc_q
);
    logic [W-1:0] dout_q, dir_q, mask_q, oe_w, omc_w, imc_w;
    logic         omc_wr;

    assign omc_wr = bus_wr && (bus_addr == SEL_OMC);

    ioport_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .logic_oe(logic_oe), .dout_q(dout_q), .dir_q(dir_q), .mask_q(mask_q), .oe(oe_w)
    );

    ioport_macrocell #(.W(W)) u_mc (
        .clk(clk), .rst_n(rst_n), .cpu_wr(omc_wr), .wdata(bus_wdata), .mask(mask_q),
        .mc_load(mc_load), .mc_next(mc_next), .pin_in(pin_in), .imc_le(imc_le),
        .omc_q(omc_w), .imc_q(imc_w)
    );

    ioport_readmux #(.W(W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr), .pin_in(pin_in),
        .dout(dout_q), .dir(dir_q), .omc(omc_w), .mask(mask_q), .imc(imc_w),
        .oe(oe_w), .rdata(bus_rdata)
    );

    assign pin_out = dout_q;
    assign pin_oe  = oe_w;
    assign mc_q    = omc_w;
    assign imc_q   = imc_w;

    // R2: the pin data follows an output data write one cycle later
    p_dout_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DOUT) |=> (pin_out == $past(bus_wdata)))
        else $error("p_dout_wr_r2");

    // R3: a logic-side enable term always turns its driver on
    p_oe_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & logic_oe) == logic_oe))
        else $error("p_oe_term_r3");
endmodule

// File: tb/sim_ioport_regs.sv
`timescale 1ns/1ps
module sim_ioport_regs;
    localparam int W = 8;
    localparam real TCK = 4.0;

    logic clk = 0;
    logic rst_n = 0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [W-1:0] bus_wdata = '0, bus_rdata;
    logic [W-1:0] pin_in = '0, pin_out, pin_oe, logic_oe = '0;
    logic mc_load = 0, imc_le = 0;
    logic [W-1:0] mc_next = '0, mc_q, imc_q;

    int checks = 0;
    int errors = 0;

    always #(TCK/2) clk = ~clk;

    ioport_regs #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .logic_oe(logic_oe), .mc_load(mc_load), .mc_next(mc_next),
        .mc_q(mc_q), .imc_le(imc_le), .imc_q(imc_q)
    );

    typedef struct packed {
        logic       rd;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] pins;
        logic [7:0] loe;
        logic [7:0] expv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 8'hA5, 8'h00, 8'h00, 8'h00, 8'd2},  // R2 write output data
        '{1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 8'hA5, 8'd2},  // R2 readback
        '{1'b0, 3'd2, 8'h0F, 8'h00, 8'h00, 8'h00, 8'd3},
        '{1'b1, 3'd2, 8'h00, 8'h00, 8'h00, 8'h0F, 8'd3},  // R3 direction readback
        '{1'b1, 3'd6, 8'h00, 8'h00, 8'h30, 8'h3F, 8'd3},  // R3 OR of dir and logic term
        '{1'b1, 3'd0, 8'h00, 8'h5C, 8'h00, 8'h5C, 8'd1},  // R1 live pins
        '{1'b1, 3'd0, 8'h00, 8'hC3, 8'h00, 8'hC3, 8'd1},  // R1 live pins
        '{1'b0, 3'd4, 8'hF0, 8'h00, 8'h00, 8'h00, 8'd5},
        '{1'b1, 3'd4, 8'h00, 8'h00, 8'h00, 8'hF0, 8'd5},  // R5 mask readback
        '{1'b0, 3'd3, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd4},
        '{1'b1, 3'd3, 8'h00, 8'h00, 8'h00, 8'h0F, 8'd4},  // R4 high nibble blocked
        '{1'b0, 3'd4, 8'h00, 8'h00, 8'h00, 8'h00, 8'd5},
        '{1'b0, 3'd3, 8'hAA, 8'h00, 8'h00, 8'h00, 8'd6},
        '{1'b1, 3'd3, 8'h00, 8'h00, 8'h00, 8'hAA, 8'd6},  // R6 no bits blocked
        '{1'b0, 3'd4, 8'h3C, 8'h00, 8'h00, 8'h00, 8'd4},
        '{1'b0, 3'd3, 8'h55, 8'h00, 8'h00, 8'h00, 8'd4},
        '{1'b1, 3'd3, 8'h00, 8'h00, 8'h00, 8'h69, 8'd4},  // R4 middle band blocked
        '{1'b0, 3'd6, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd9},
        '{1'b1, 3'd6, 8'h00, 8'h00, 8'h00, 8'h0F, 8'd9},  // R9 enable view not writable
        '{1'b0, 3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd9},
        '{1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 8'hA5, 8'd9},  // R9 pin address write ignored
        '{1'b0, 3'd5, 8'hFF, 8'h00, 8'h00, 8'h00, 8'd9},
        '{1'b1, 3'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'd9},  // R9 input macrocells untouched
        '{1'b1, 3'd7, 8'h00, 8'h00, 8'h00, 8'h00, 8'd10}  // R10 unmapped reads zero
    };

    task automatic check(input logic [7:0] act, input logic [7:0] expv, input string req);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic do_rd(input logic [2:0] a);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state at the ports
        check(bus_rdata, 8'h00, "R11 rdata");
        check(pin_out, 8'h00, "R11 pin_out");
        check(pin_oe, 8'h00, "R11 pin_oe");
        check(mc_q, 8'h00, "R11 mc_q");
        rst_n = 1;
        @(negedge clk);
        do_rd(3'd4);
        check(bus_rdata, 8'h00, "R5 mask reset");

        for (int i = 0; i < NV; i++) begin
            pin_in = VECS[i].pins;
            logic_oe = VECS[i].loe;
            if (VECS[i].rd) begin
                do_rd(VECS[i].addr);
                check(bus_rdata, VECS[i].expv, $sformatf("R%0d vec%0d", VECS[i].req, i));
            end else begin
                do_wr(VECS[i].addr, VECS[i].data);
            end
        end

        check(pin_out, 8'hA5, "R2 pin_out");
        logic_oe = 8'h30;
        #1 check(pin_oe, 8'h3F, "R3 pin_oe");
        logic_oe = 8'h00;

        // R8 capture with enable, hold without
        pin_in = 8'h96; imc_le = 1;
        @(negedge clk);
        imc_le = 0; pin_in = 8'h11;
        @(negedge clk);
        check(imc_q, 8'h96, "R8 imc_q hold");
        do_rd(3'd5);
        check(bus_rdata, 8'h96, "R8 imc read");

        // R7 coincident CPU write and logic load (mask 0x3C, data 0x0F vs 0xF0)
        mc_load = 1; mc_next = 8'hF0;
        do_wr(3'd3, 8'h0F);
        check(mc_q, 8'h33, "R7 cpu wins unmasked");
        mc_next = 8'h81;
        @(negedge clk);
        mc_load = 0;
        check(mc_q, 8'h81, "R7 logic load all bits");
        do_rd(3'd3);
        check(bus_rdata, 8'h81, "R6 omc read");

        // R10 read data holds without a strobe; R1 sampled at the strobe edge
        pin_in = 8'h12;
        do_rd(3'd0);
        pin_in = 8'h34;
        @(negedge clk);
        @(negedge clk);
        check(bus_rdata, 8'h12, "R10 rdata hold");

        // R11 reset in mid-run
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check(pin_out, 8'h00, "R11 dout cleared");
        check(mc_q, 8'h00, "R11 omc cleared");
        check(imc_q, 8'h00, "R11 imc cleared");
        check(pin_oe, 8'h00, "R11 dir cleared");
        do_rd(3'd4);
        check(bus_rdata, 8'h00, "R11 mask cleared");

        finish_run();
    end
endmodule